// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block keeps a bus-readable copy of every word of a one-time-programmable fuse array, so that software reads never reach the slow fuse cells. The shadow words sit in an address window starting at byte offset 0x400, one word every 0x10 bytes. A small control word reports whether a copy from the fuses is in flight and whether an access rule was broken.

A reload walks the whole fuse array in ascending order. It starts automatically out of reset and again whenever software sets the reload command bit through the set alias. Each fuse word costs `STROBE_READ+1` cycles. While the walk runs, the block refuses shadow writes but keeps serving reads.

Per-word read and write lock vectors come in as ports. A read of a read-locked word returns a fixed poison pattern. A write to a write-locked word, or any shadow write during a reload, leaves the word untouched. Every one of these violations raises a single sticky error flag. While that flag is set, a reload request is refused, so software has to clear the flag through the clear alias first.

Top module: `fuse_shadow_bank`

## Requirements
- R1: A bus read of byte address 0x400 + 0x10*i, for i below `WORDS`, returns shadow word i on `bus_rdata` with `bus_rvalid` high one cycle later. Any other address reads as 0 and raises no error, and a write to it changes no shadow word.
- R2: After reset all shadow words hold 0 and a reload is already running. The control word reads 0x500.
- R3: A write to the set alias (0x004) with bit 10 set, while idle and error-free, starts a reload. The control word then shows busy (bit 8) and reload (bit 10) for exactly `WORDS*(STROBE_READ+1)` cycles, after which both clear by themselves.
- R4: The reload copies word k at the end of its (k+1)-th slot of `STROBE_READ+1` cycles, in ascending order. Fuse word i holds (i*0x9E3779B1) XOR `FUSE_SEED`.
- R5: A reload request is refused while the error flag is set, and busy stays low.
- R6: A read of a word whose `rd_lock` bit is set returns 0xBADABADA and sets the error flag.
- R7: A shadow write during a reload sets the error flag and leaves the word unchanged.
- R8: A write to a word whose `wr_lock` bit is set sets the error flag and leaves the word unchanged.
- R9: The error flag (control bit 9) is sticky. Only a write to the clear alias (0x008) with bit 9 set clears it.
- R10: Shadow reads are served during a reload and return the current shadow contents.
- R11: A write to an unlocked word while idle replaces its contents.
- R12: The control word at 0x000 is read-only: writes there have no effect, and its bits other than 8, 9 and 10 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High the cycle after a read access |
| rd_lock | input | WORDS | Per-word read lock |
| wr_lock | input | WORDS | Per-word write lock |

## Verification
The bench builds the block with `WORDS=64`, `STROBE_READ=2` and a non-zero `FUSE_SEED`. This gives a full reload of 192 cycles, short enough to be timed exactly to its last cycle and repeated several times in one run. The 64-word build also makes the first address past the window (word 64) a reachable out-of-range case. Reading word 10 on each side of its copy edge pins down the slot arithmetic and the ascending order, and randomly placed locks exercise the poison and error paths over many words.

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank #(
  parameter int          WORDS       = 128,
  parameter int          STROBE_READ = 3,
  parameter int          ADDR_W      = 12,
  parameter logic [31:0] FUSE_SEED   = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [WORDS-1:0]  rd_lock,
  input  logic [WORDS-1:0]  wr_lock
);

  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int CNT_W = $clog2(STROBE_READ + 2);
  localparam logic [ADDR_W-1:0] WIN_BASE  = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] CTRL_ADR  = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] SET_ADR   = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] CLR_ADR   = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] WIN_WORDS = ADDR_W'(WORDS);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(WORDS - 1);
  localparam logic [CNT_W-1:0]  SLOT_END  = CNT_W'(STROBE_READ);
  localparam logic [31:0]       POISON    = 32'hBADA_BADA;

  function automatic logic [31:0] fuse_word(input logic [IDX_W-1:0] i);
    return (32'(i) * 32'h9E37_79B1) ^ FUSE_SEED;
  endfunction

  logic [31:0]      shadow [WORDS];
  logic             reload_q, error_q;
  logic [IDX_W-1:0] ptr;
  logic [CNT_W-1:0] cnt;

  logic [ADDR_W-1:0] off, woff;
  logic [IDX_W-1:0]  idx;
  logic              win_hit, rd_en, wr_en;
  logic              set_wr, clr_wr, ctrl_rd;
  logic              wr_refused, wr_ok, rd_poison, err_evt, start_ok;
  logic [31:0]       rd_val;

  assign off     = bus_addr - WIN_BASE;
  assign woff    = off >> 4;
  assign idx     = woff[IDX_W-1:0];
  assign win_hit = (bus_addr >= WIN_BASE) && (off[3:0] == 4'd0) && (woff < WIN_WORDS);

  assign rd_en   = bus_en && !bus_we;
  assign wr_en   = bus_en && bus_we;
  assign ctrl_rd = rd_en && (bus_addr == CTRL_ADR);
  assign set_wr  = wr_en && (bus_addr == SET_ADR);
  assign clr_wr  = wr_en && (bus_addr == CLR_ADR);

  assign wr_refused = wr_en && win_hit && (reload_q || wr_lock[idx]);
  assign wr_ok      = wr_en && win_hit && !reload_q && !wr_lock[idx];
  assign rd_poison  = rd_en && win_hit && rd_lock[idx];
  assign err_evt    = wr_refused || rd_poison;
  assign start_ok   = set_wr && bus_wdata[10] && !error_q && !reload_q;

  always_comb begin
    rd_val = 32'd0;
    if (ctrl_rd)
      rd_val = {21'd0, reload_q, error_q, reload_q, 8'd0};
    else if (win_hit)
      rd_val = rd_lock[idx] ? POISON : shadow[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q   <= 1'b1;
      error_q    <= 1'b0;
      ptr        <= '0;
      cnt        <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= 32'd0;
      for (int i = 0; i < WORDS; i++) shadow[i] <= 32'd0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_val;

      if (reload_q) begin
        if (cnt == SLOT_END) begin
          shadow[ptr] <= fuse_word(ptr);
          cnt <= '0;
          if (ptr == LAST_IDX) reload_q <= 1'b0;
          else                 ptr <= ptr + IDX_W'(1);
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else if (start_ok) begin
        reload_q <= 1'b1;
        ptr      <= '0;
        cnt      <= '0;
      end

      if (wr_ok) shadow[idx] <= bus_wdata;

      if (err_evt)                      error_q <= 1'b1;
      else if (clr_wr && bus_wdata[9])  error_q <= 1'b0;
    end
  end

  // R7 R8
  err_on_refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_refused |=> error_q);

  // R6
  poison_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_poison |=> (bus_rdata == POISON) && error_q && bus_rvalid);

  // R5
  reload_needs_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reload_q) |-> !$past(error_q));

  // R4
  reload_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q && $past(reload_q) && (ptr != $past(ptr))) |-> (ptr == $past(ptr) + IDX_W'(1)));

  // R9
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (error_q && !(clr_wr && bus_wdata[9])) |=> error_q);

endmodule

// File: tb/fuse_shadow_bank_tb.sv
module fuse_shadow_bank_tb;
  localparam int          W    = 64;
  localparam int          SR   = 2;
  localparam logic [31:0] SEED = 32'h5A5A_0F0F;
  localparam int          RL   = W * (SR + 1);

  logic        clk = 0, rst_n = 0;
  logic        bus_en = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_rvalid;
  logic [W-1:0] rd_lock, wr_lock;

  fuse_shadow_bank #(.WORDS(W), .STROBE_READ(SR), .ADDR_W(12), .FUSE_SEED(SEED)) u_dut (
    .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .bus_rvalid, .rd_lock, .wr_lock);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, now_c = 0;
  bit done = 0;
  logic [31:0] m [W];
  bit err_m;
  logic [31:0] q;

  function automatic logic [31:0] fuse_f(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ SEED;
  endfunction

  function automatic logic [11:0] wa(input int i);
    return 12'h400 + 12'(i * 16);
  endfunction

  task automatic check(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic op(input bit we, input logic [11:0] a, input logic [31:0] d, output logic [31:0] r);
    bus_en = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    r = bus_rdata;
    bus_en = 0; bus_we = 0;
    now_c++;
  endtask

  task automatic idle_until(input int s);
    while (now_c + 1 < s) begin @(negedge clk); now_c++; end
  endtask

  task automatic rd_word(input int i, input string r);
    logic [31:0] v;
    op(0, wa(i), 0, v);
    if (rd_lock[i]) begin check(r, v, 32'hBADA_BADA); err_m = 1; end
    else check(r, v, m[i]);
  endtask

  task automatic wr_word(input int i, input logic [31:0] d);
    logic [31:0] v;
    op(1, wa(i), d, v);
    if (wr_lock[i]) err_m = 1; else m[i] = d;
  endtask

  task automatic ctrl_chk(input logic [31:0] exp, input string r);
    logic [31:0] v;
    op(0, 12'h000, 0, v);
    check(r, v, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, polls;
    void'($urandom(32'd11));
    for (int i = 0; i < W; i++) begin
      rd_lock[i] = ($urandom % 8) == 0;
      wr_lock[i] = ($urandom % 8) == 0;
      m[i] = 32'd0;
    end
    rd_lock[0] = 0; wr_lock[0] = 0; rd_lock[1] = 1;
    wr_lock[2] = 1; rd_lock[2] = 0;
    rd_lock[10] = 0; wr_lock[10] = 0; rd_lock[63] = 0; wr_lock[63] = 0;
    err_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2: reset state, reload running, shadows zero
    ctrl_chk(32'h500, "R2 ctrl after reset");
    rd_word(0, "R2 word0 zero after reset");
    polls = 0;
    do begin op(0, 12'h000, 0, q); polls++; end while (q[8] && polls < 1000);
    check("R2 auto reload completes", q, 32'h0);
    for (int i = 0; i < W; i++) m[i] = fuse_f(i);

    // R4 R6: all words after reload
    for (int i = 0; i < W; i++) rd_word(i, "R4/R6 read after reload");
    ctrl_chk({22'd0, err_m, 9'd0}, "R6 error flag after locked reads");
    op(1, 12'h008, 32'h200, q); err_m = 0;
    ctrl_chk(32'h0, "R9 clear via clear alias");

    // R11, R8
    wr_word(10, 32'hCAFE_0010);
    wr_word(0, 32'h1234_5678);
    rd_word(0, "R11 unlocked write");
    ctrl_chk(32'h0, "R11 no error on unlocked write");
    wr_word(2, 32'hDEAD_0002);
    rd_word(2, "R8 locked word unchanged");
    ctrl_chk(32'h200, "R8 error on locked write");
    op(0, 12'h000, 0, q);
    check("R9 error sticky across reads", q, 32'h200);
    op(1, 12'h008, 32'h200, q); err_m = 0;

    // R1: outside the window
    op(0, wa(W), 0, q);      check("R1 beyond window reads 0", q, 0);
    op(0, 12'h404, 0, q);    check("R1 misaligned reads 0", q, 0);
    op(1, 12'h404, 32'hFFFF_FFFF, q);
    op(1, wa(W), 32'hFFFF_FFFF, q);
    rd_word(0, "R1 stray writes leave word0");
    ctrl_chk(32'h0, "R1 no error from stray accesses");
    op(0, wa(3), 0, q);
    check("R1 rvalid after read", {31'd0, bus_rvalid}, 32'd1);

    // R12
    op(1, 12'h000, 32'hFFFF_FFFF, q);
    op(1, 12'h008, 32'h400, q);
    ctrl_chk(32'h0, "R12 ctrl read-only");

    // R3 R4 R7 R10: timed reload
    op(1, 12'h004, 32'h400, q);
    t0 = now_c;
    wr_word(63, 32'h0BAD_0063); m[63] = fuse_f(63); err_m = 1;
    op(0, wa(63), 0, q);
    check("R7 write during reload ignored", q, fuse_f(63));
    ctrl_chk(32'h700, "R3/R7 busy, reload and error");
    op(1, 12'h008, 32'h200, q); err_m = 0;
    idle_until(t0 + 11 * (SR + 1));
    op(0, wa(10), 0, q);
    check("R10 word10 before its slot", q, 32'hCAFE_0010);
    op(0, wa(10), 0, q);
    check("R4 word10 after its slot", q, fuse_f(10));
    idle_until(t0 + RL);
    ctrl_chk(32'h500, "R3 busy on last cycle");
    ctrl_chk(32'h0, "R3 busy clears");
    for (int i = 0; i < W; i++) m[i] = fuse_f(i);
    rd_word(0, "R4 word0 restored");

    // R5
    rd_word(1, "R6 locked read");
    op(1, 12'h004, 32'h400, q);
    ctrl_chk(32'h200, "R5 reload refused with error");
    op(1, 12'h008, 32'h200, q); err_m = 0;
    ctrl_chk(32'h0, "R9 error cleared");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k, i;
      k = $urandom % 4;
      i = $urandom % W;
      case (k)
        0: rd_word(i, "R6/R1 random read");
        1: wr_word(i, $urandom);
        2: ctrl_chk({22'd0, err_m, 9'd0}, "R9 random ctrl");
        default: begin op(1, 12'h008, 32'h200, q); err_m = 0; end
      endcase
    end
    for (int i = 0; i < W; i++) rd_word(i, "R11/R8 final sweep");
    finish_run();
  end
endmodule